// File: doc/BRIEF.md
# Read Calibration Sequencer

This sequencer runs once, after SDRAM initialization and write leveling, to bring read capture into a working state on every byte lane. It first derives each lane's DQ output delay from that lane's leveled DQS delay, pulled back by half a bit time. It then writes a block of pseudo-random words to memory, unless the fixed-pattern mode is selected. After that it works through the lanes one at a time.

For each lane it first finds a bitslip setting that captures correctly with the input delay parked at mid-range. It then sweeps every input delay tap and records the first and last passing taps. Finally it parks the lane's delay at the centre of that window.

Memory traffic goes through a single request/acknowledge port. The input delay elements are driven by per-lane reset and increment pulses. The host starts the sequencer with a pulse and watches the busy, done and error flags. It then reads a per-lane result table by lane index.

Top module: `rcal_seq`

## Requirements
- R1: When a calibration starts, each lane's DQ output delay becomes that lane's leveled DQS delay minus HALF_BIT_TAPS (8), clamped at 0, and `odly_vld_o` goes high before any memory request.
- R2: In pseudo-random mode, WORDS (8) writes go to addresses 0..7 in order. Word 0 uses the 32-bit seed 0xACE12D5B and the state advances once per word. The state update is {s[30:0], s[31]^s[21]^s[1]^s[0]}, and the 64-bit word is {~s, s}. Lane L owns data bits [8L+7:8L]. Every readback pass regenerates the same sequence from the seed, and a request holds its address until acknowledged.
- R3: For each lane, bitslip values 0,1,...,7 are tried in that order with the tap at 16. The first value for which all WORDS readback bytes of that lane match is kept, and it is reported in the table.
- R4: After the bitslip is found, taps 0..31 are each tested once, in increasing order. The lowest and highest passing taps are reported as window first and last.
- R5: The chosen tap is floor((first+last)/2). It is reported in the table, and the lane's delay element is left at that tap through a reset pulse followed by single increments. The reset and increment pulses never overlap.
- R6: A lane with no passing bitslip is flagged failed and reports 0 for its slip, first, last and tap fields. The remaining lanes are still calibrated, and the run ends with `done_o` and `err_o` both high.
- R7: With `fixed_pat_i` high at start, no writes are issued. The expected byte on every lane is 0xFF for even addresses and 0x00 for odd addresses.
- R8: `busy_o` is high from the cycle after start until completion, and `busy_o` and `done_o` are never high together. A start pulse while busy is ignored. `done_o` and `err_o` hold until the next start.
- R9: No read request is issued until more than SETTLE (4) cycles have passed since the last tap reset or increment pulse.
- R10: After reset, the busy, done, error, output-delay-valid, memory request and all tap pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| fixed_pat_i | input | 1 | Select the DRAM fixed-pattern read mode (sampled at start) |
| wl_dly_i | input | LANES*TAP_W | Leveled DQS delay per lane |
| busy_o | output | 1 | Calibration running |
| done_o | output | 1 | Calibration finished |
| err_o | output | 1 | At least one lane failed |
| odly_o | output | LANES*TAP_W | DQ output delay per lane |
| odly_vld_o | output | 1 | Output delays valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Request acknowledge; read data valid |
| mem_rdata_i | input | DW | Read data |
| tap_rst_o | output | LANES | Per-lane input delay reset pulse |
| tap_inc_o | output | LANES | Per-lane input delay increment pulse |
| slip_o | output | LANES*SLIP_W | Per-lane bitslip setting |
| tbl_sel_i | input | LANE_W | Table lane select |
| tbl_slip_o | output | SLIP_W | Selected lane bitslip |
| tbl_first_o | output | TAP_W | Selected lane window first tap |
| tbl_last_o | output | TAP_W | Selected lane window last tap |
| tbl_ctr_o | output | TAP_W | Selected lane chosen tap |
| tbl_fail_o | output | 1 | Selected lane failed |

## Verification
A corrupted tap counter or window register shows up at the end of a run. The reported window is then off from the bench's model, or the model's delay element is left away from the reported centre. A wrong pattern state shows up earlier, in the memory image right after the write pass. It also makes whole lanes fail, so the error flag and the table show it once the run ends. A broken settle count shows up within a single tap step, as a read request arriving too soon after a pulse.

// File: rtl/rcal_pkg.sv
package rcal_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ODLY, S_WR, S_LANE, S_TRST, S_TINC,
    S_SETTLE, S_RD, S_EVAL, S_CTR, S_NEXT, S_FIN
  } cal_st_e;

  typedef enum logic [1:0] {PH_SLIP, PH_SWEEP, PH_CENTRE} cal_ph_e;
endpackage

// File: rtl/rcal_pattern.sv
module rcal_pattern #(
  parameter int          DW   = 64,
  parameter logic [31:0] SEED = 32'hACE1_2D5B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          fixed_i,
  input  logic          odd_i,
  output logic [DW-1:0] word_o
);
  logic [31:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (load_i) s_q <= SEED;
    else if (step_i) s_q <= {s_q[30:0], s_q[31] ^ s_q[21] ^ s_q[1] ^ s_q[0]};
  end

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      if (fixed_i) word_o[i] = ~odd_i;
      else         word_o[i] = s_q[i % 32] ^ (((i / 32) % 2) == 1);
    end
  end
endmodule

// File: rtl/rcal_lane_cmp.sv
module rcal_lane_cmp #(
  parameter int LANES  = 8,
  parameter int LANE_W = 3
) (
  input  logic [LANES*8-1:0] rdata_i,
  input  logic [LANES*8-1:0] expect_i,
  input  logic [LANE_W-1:0]  lane_i,
  output logic               match_o
);
  logic [7:0] got, exp_b;
  always_comb begin
    got     = rdata_i[lane_i*8 +: 8];
    exp_b   = expect_i[lane_i*8 +: 8];
    match_o = (got == exp_b);
  end
endmodule

// File: rtl/rcal_window.sv
module rcal_window #(
  parameter int TAP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic [TAP_W-1:0] first_o,
  output logic [TAP_W-1:0] last_o,
  output logic [TAP_W-1:0] ctr_o
);
  logic [TAP_W:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_o <= 1'b0;
      first_o <= '0;
      last_o  <= '0;
    end else if (clr_i) begin
      found_o <= 1'b0;
      first_o <= '0;
      last_o  <= '0;
    end else if (smp_i && pass_i) begin
      if (!found_o) first_o <= tap_i;
      last_o  <= tap_i;
      found_o <= 1'b1;
    end
  end

  assign sum   = {1'b0, first_o} + {1'b0, last_o};
  assign ctr_o = sum[TAP_W:1];

  p_last_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && pass_i && !clr_i) |=> (last_o == $past(tap_i)));
  p_first_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && pass_i && !found_o && !clr_i) |=> (first_o == $past(tap_i)));
  p_ctr_inside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (first_o <= last_o && ctr_o >= first_o && ctr_o <= last_o));
endmodule

// File: rtl/rcal_seq.sv
module rcal_seq
  import rcal_pkg::*;
#(
  parameter int          LANES         = 8,
  parameter int          TAPS          = 32,
  parameter int          HALF_BIT_TAPS = 8,
  parameter int          NUM_SLIP      = 8,
  parameter int          SETTLE        = 4,
  parameter int          WORDS         = 8,
  parameter logic [31:0] SEED          = 32'hACE1_2D5B,
  localparam int TAP_W  = $clog2(TAPS),
  localparam int SLIP_W = $clog2(NUM_SLIP),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int DW     = LANES * 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    fixed_pat_i,
  input  logic [LANES*TAP_W-1:0]  wl_dly_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic [LANES*TAP_W-1:0]  odly_o,
  output logic                    odly_vld_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic [LANES-1:0]        tap_rst_o,
  output logic [LANES-1:0]        tap_inc_o,
  output logic [LANES*SLIP_W-1:0] slip_o,
  input  logic [LANE_W-1:0]       tbl_sel_i,
  output logic [SLIP_W-1:0]       tbl_slip_o,
  output logic [TAP_W-1:0]        tbl_first_o,
  output logic [TAP_W-1:0]        tbl_last_o,
  output logic [TAP_W-1:0]        tbl_ctr_o,
  output logic                    tbl_fail_o
);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int MID   = TAPS / 2;

  cal_st_e st;
  cal_ph_e ph;
  logic [LANE_W-1:0] lane;
  logic [TAP_W-1:0]  tap, target;
  logic [ADDR_W-1:0] word;
  logic [SET_W-1:0]  scnt;
  logic              all_ok, fixed_q, done_q, err_q, odly_vld_q;
  logic [LANES-1:0]  fail_tab;
  logic [SLIP_W-1:0] slip_tab  [LANES];
  logic [TAP_W-1:0]  first_tab [LANES];
  logic [TAP_W-1:0]  last_tab  [LANES];
  logic [TAP_W-1:0]  ctr_tab   [LANES];
  logic [TAP_W-1:0]  odly_q    [LANES];

  logic [DW-1:0]     pat_word;
  logic              pat_load, pat_step, lane_match, settle_end;
  logic              win_clr, win_smp, win_found;
  logic [TAP_W-1:0]  win_first, win_last, win_ctr;

  assign settle_end = (st == S_SETTLE) && (scnt == SET_W'(SETTLE - 1));
  assign pat_load   = ((st == S_IDLE) && start_i) ||
                      (settle_end && (tap >= target) && (ph != PH_CENTRE));
  assign pat_step   = ((st == S_WR) || (st == S_RD)) && mem_ack_i;
  assign win_clr    = (st == S_LANE) || ((st == S_EVAL) && (ph == PH_SLIP) && all_ok);
  assign win_smp    = (st == S_EVAL) && (ph == PH_SWEEP);

  rcal_pattern #(.DW(DW), .SEED(SEED)) u_pat (
    .clk_i, .rst_ni, .load_i(pat_load), .step_i(pat_step),
    .fixed_i(fixed_q), .odd_i(word[0]), .word_o(pat_word)
  );

  rcal_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
    .rdata_i(mem_rdata_i), .expect_i(pat_word), .lane_i(lane), .match_o(lane_match)
  );

  rcal_window #(.TAP_W(TAP_W)) u_win (
    .clk_i, .rst_ni, .clr_i(win_clr), .smp_i(win_smp), .pass_i(all_ok), .tap_i(tap),
    .found_o(win_found), .first_o(win_first), .last_o(win_last), .ctr_o(win_ctr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE;  ph <= PH_SLIP;  lane <= '0;  tap <= '0;  target <= '0;
      word <= '0;  scnt <= '0;  all_ok <= 1'b0;  fixed_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;  odly_vld_q <= 1'b0;  fail_tab <= '0;
      for (int i = 0; i < LANES; i++) begin
        slip_tab[i] <= '0;  first_tab[i] <= '0;  last_tab[i] <= '0;
        ctr_tab[i]  <= '0;  odly_q[i]    <= '0;
      end
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          done_q <= 1'b0;  err_q <= 1'b0;  odly_vld_q <= 1'b0;  fail_tab <= '0;
          fixed_q <= fixed_pat_i;  word <= '0;  lane <= '0;
          for (int i = 0; i < LANES; i++) begin
            slip_tab[i] <= '0;  first_tab[i] <= '0;  last_tab[i] <= '0;  ctr_tab[i] <= '0;
          end
          st <= S_ODLY;
        end
        S_ODLY: begin
          for (int i = 0; i < LANES; i++) begin
            if (wl_dly_i[i*TAP_W +: TAP_W] >= TAP_W'(HALF_BIT_TAPS))
              odly_q[i] <= wl_dly_i[i*TAP_W +: TAP_W] - TAP_W'(HALF_BIT_TAPS);
            else
              odly_q[i] <= '0;
          end
          odly_vld_q <= 1'b1;
          st <= fixed_q ? S_LANE : S_WR;
        end
        S_WR: if (mem_ack_i) begin
          word <= word + 1'b1;
          if (word == ADDR_W'(WORDS - 1)) st <= S_LANE;
        end
        S_LANE: begin
          ph <= PH_SLIP;  slip_tab[lane] <= '0;  target <= TAP_W'(MID);  st <= S_TRST;
        end
        S_TRST: begin tap <= '0;  scnt <= '0;  st <= S_SETTLE; end
        S_TINC: begin tap <= tap + 1'b1;  scnt <= '0;  st <= S_SETTLE; end
        S_SETTLE: begin
          scnt <= scnt + 1'b1;
          if (settle_end) begin
            scnt <= '0;
            if (tap < target)          st <= S_TINC;
            else if (ph == PH_CENTRE)  st <= S_NEXT;
            else begin word <= '0;  all_ok <= 1'b1;  st <= S_RD; end
          end
        end
        S_RD: if (mem_ack_i) begin
          all_ok <= all_ok & lane_match;
          word   <= word + 1'b1;
          if (word == ADDR_W'(WORDS - 1)) st <= S_EVAL;
        end
        S_EVAL: begin
          if (ph == PH_SLIP) begin
            if (all_ok) begin
              ph <= PH_SWEEP;  target <= '0;  st <= S_TRST;
            end else if (slip_tab[lane] == SLIP_W'(NUM_SLIP - 1)) begin
              fail_tab[lane] <= 1'b1;  slip_tab[lane] <= '0;  st <= S_NEXT;
            end else begin
              slip_tab[lane] <= slip_tab[lane] + 1'b1;  target <= TAP_W'(MID);  st <= S_TRST;
            end
          end else if (tap == TAP_W'(TAPS - 1)) begin
            st <= S_CTR;
          end else begin
            target <= tap + 1'b1;  st <= S_TINC;
          end
        end
        S_CTR: begin
          if (win_found) begin
            first_tab[lane] <= win_first;  last_tab[lane] <= win_last;
            ctr_tab[lane]   <= win_ctr;    target <= win_ctr;
            ph <= PH_CENTRE;  st <= S_TRST;
          end else begin
            fail_tab[lane] <= 1'b1;  slip_tab[lane] <= '0;  st <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (lane == LANE_W'(LANES - 1)) st <= S_FIN;
          else begin lane <= lane + 1'b1;  st <= S_LANE; end
        end
        S_FIN: begin done_q <= 1'b1;  err_q <= |fail_tab;  st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      tap_rst_o[i] = (st == S_TRST) && (lane == LANE_W'(i));
      tap_inc_o[i] = (st == S_TINC) && (lane == LANE_W'(i));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_out
    assign odly_o[g*TAP_W +: TAP_W]   = odly_q[g];
    assign slip_o[g*SLIP_W +: SLIP_W] = slip_tab[g];
  end

  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign odly_vld_o  = odly_vld_q;
  assign mem_req_o   = (st == S_WR) || (st == S_RD);
  assign mem_we_o    = (st == S_WR);
  assign mem_addr_o  = word;
  assign mem_wdata_o = pat_word;
  assign tbl_slip_o  = slip_tab[tbl_sel_i];
  assign tbl_first_o = first_tab[tbl_sel_i];
  assign tbl_last_o  = last_tab[tbl_sel_i];
  assign tbl_ctr_o   = ctr_tab[tbl_sel_i];
  assign tbl_fail_o  = fail_tab[tbl_sel_i];

  // cycles since last tap pulse, for the settle guard
  logic [SET_W:0] since_step;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_step <= (SET_W+1)'(SETTLE + 1);
    else if (|{tap_rst_o, tap_inc_o})   since_step <= '0;
    else if (since_step <= (SET_W+1)'(SETTLE)) since_step <= since_step + 1'b1;
  end

  p_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (since_step >= (SET_W+1)'(SETTLE)));
  p_err_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_busy_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_no_wr_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !fixed_q);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_pulse_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tap_rst_o, tap_inc_o}));
  p_odly_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> odly_vld_o);
endmodule

// File: tb/tb_rcal_seq.sv
module tb_rcal_seq;
  localparam int LANES = 8, TAPS = 32, HALF = 8, SETTLE = 4, WORDS = 8, MID = 16;
  localparam logic [31:0] SEED = 32'hACE1_2D5B;

  logic        clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, fixed_pat_i = 1'b0;
  logic [39:0] wl_dly_i = '0;
  logic        busy_o, done_o, err_o, odly_vld_o;
  logic [39:0] odly_o;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [2:0]  mem_addr_o;
  logic [63:0] mem_wdata_o, mem_rdata_i = '0;
  logic [7:0]  tap_rst_o, tap_inc_o;
  logic [23:0] slip_o;
  logic [2:0]  tbl_sel_i = '0;
  logic [2:0]  tbl_slip_o;
  logic [4:0]  tbl_first_o, tbl_last_o, tbl_ctr_o;
  logic        tbl_fail_o;

  rcal_seq dut (.clk_i(clk), .*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, wr_count = 0, settle_bad = 0, since = 100;
  logic [63:0] mem [WORDS];
  int btap [LANES];
  int good_slip [LANES], lo [LANES], hi [LANES];
  logic fixed_mode = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lfsr_word(input int n);
    logic [31:0] s = SEED;
    for (int k = 0; k < n; k++) s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    return {~s, s};
  endfunction

  // PHY and memory model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_ni) continue;
      for (int l = 0; l < LANES; l++) begin
        if (tap_rst_o[l]) btap[l] = 0;
        else if (tap_inc_o[l]) btap[l]++;
      end
      if (|{tap_rst_o, tap_inc_o}) since = 0; else since++;
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          wr_count++;
        end else begin
          if (since <= SETTLE) settle_bad++;
          for (int l = 0; l < LANES; l++) begin
            logic [7:0] base;
            bit pass;
            base = fixed_mode ? (mem_addr_o[0] ? 8'h00 : 8'hFF) : mem[mem_addr_o][l*8 +: 8];
            pass = (int'(slip_o[l*3 +: 3]) == good_slip[l]) && btap[l] >= lo[l] && btap[l] <= hi[l];
            mem_rdata_i[l*8 +: 8] = pass ? base : ~base;
          end
        end
        mem_ack_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_cal(input logic fx);
    int n = 0;
    fixed_mode = fx;
    fixed_pat_i = fx;
    wr_count = 0;
    settle_bad = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
    repeat (300) @(negedge clk);
    start_i = 1'b1;                       // ignored while busy
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1 && !done_o, "R8 start while busy", int'(busy_o), 1);
    while (!done_o && n < 190000) begin @(negedge clk); n++; end
  endtask

  task automatic check_results(input logic fx);
    bit any_fail = 0;
    chk(done_o && !busy_o, "R8 done", int'(done_o), 1);
    chk(settle_bad == 0, "R9 settle before read", settle_bad, 0);
    chk(odly_vld_o, "R1 odly valid", int'(odly_vld_o), 1);
    if (fx) chk(wr_count == 0, "R7 no writes", wr_count, 0);
    else begin
      chk(wr_count == WORDS, "R2 write count", wr_count, WORDS);
      for (int w = 0; w < WORDS; w++)
        chk(mem[w] == lfsr_word(w), "R2 pattern word", int'(mem[w][31:0]), int'(lfsr_word(w)));
    end
    for (int l = 0; l < LANES; l++) begin
      int dq, eo;
      bit ok;
      dq = int'(wl_dly_i[l*5 +: 5]);
      eo = (dq >= HALF) ? dq - HALF : 0;
      chk(int'(odly_o[l*5 +: 5]) == eo, "R1 odly", int'(odly_o[l*5 +: 5]), eo);
      tbl_sel_i = 3'(l);
      #1;
      ok = good_slip[l] < 8 && lo[l] <= MID && hi[l] >= MID;
      if (ok) begin
        chk(!tbl_fail_o, "R6 lane pass", int'(tbl_fail_o), 0);
        chk(int'(tbl_slip_o) == good_slip[l], "R3 slip", int'(tbl_slip_o), good_slip[l]);
        chk(int'(tbl_first_o) == lo[l], "R4 first", int'(tbl_first_o), lo[l]);
        chk(int'(tbl_last_o) == hi[l], "R4 last", int'(tbl_last_o), hi[l]);
        chk(int'(tbl_ctr_o) == (lo[l] + hi[l]) / 2, "R5 centre", int'(tbl_ctr_o), (lo[l] + hi[l]) / 2);
        chk(btap[l] == (lo[l] + hi[l]) / 2, "R5 phy tap", btap[l], (lo[l] + hi[l]) / 2);
      end else begin
        any_fail = 1;
        chk(tbl_fail_o, "R6 lane fail", int'(tbl_fail_o), 1);
        chk({tbl_slip_o, tbl_first_o, tbl_last_o, tbl_ctr_o} == '0, "R6 zero fields",
            int'({tbl_first_o, tbl_last_o}), 0);
      end
    end
    chk(err_o == any_fail, "R6 err flag", int'(err_o), int'(any_fail));
  endtask

  task automatic rand_lanes();
    for (int l = 0; l < LANES; l++) begin
      good_slip[l] = int'($urandom % 8);
      lo[l] = 4 + int'($urandom % 13);
      hi[l] = 16 + int'($urandom % 13);
      wl_dly_i[l*5 +: 5] = 5'($urandom % 32);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int l = 0; l < LANES; l++) btap[l] = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !odly_vld_o && !mem_req_o && tap_rst_o == '0 && tap_inc_o == '0,
        "R10 reset state", int'({busy_o, done_o, err_o, odly_vld_o, mem_req_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R10 idle after reset", int'(busy_o), 0);

    rand_lanes();
    run_cal(1'b0);
    check_results(1'b0);

    // directed corners
    rand_lanes();
    good_slip[0] = 8;  wl_dly_i[0 +: 5] = 5'd0;
    good_slip[1] = 7;  lo[1] = 0;  hi[1] = 31;  wl_dly_i[5 +: 5] = 5'(HALF);
    good_slip[2] = 0;  lo[2] = 16; hi[2] = 16;  wl_dly_i[10 +: 5] = 5'd31;
    good_slip[3] = 2;  lo[3] = 2;  hi[3] = 12;
    run_cal(1'b0);
    check_results(1'b0);

    rand_lanes();
    run_cal(1'b1);
    check_results(1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule